// File: doc/BRIEF.md
# Memory-Mapped Signed Integer Divider

This block is a division coprocessor that a host drives through 16-bit register writes. The host loads a signed numerator and a signed denominator, each 64 bits wide, as four halfwords. It selects an operand width through a two-bit mode field in the control register. It then polls a busy flag until the quotient and remainder can be read back, also as halfwords.

Any write to the control register or to an operand halfword starts a division. If a division is already in flight, the write abandons it and starts over. The busy period has a fixed length that depends only on the mode, never on the operand values. The quotient and remainder registers change only at the end of that period, all in one clock edge.

Internally, a radix-4 restoring divider works on operand magnitudes and finishes well inside the shortest busy window. A sign stage prepares the magnitudes from the operand registers and corrects the signs of the results. A countdown timer owns the busy flag and the moment the results are committed.

Top module: `divu_top`

## Requirements
- R1: After reset, every readable register returns 0, including the control word, so busy (bit 15) and the zero-divisor flag (bit 14) are both clear.
- R2: A write to the control address or to any numerator or denominator halfword sets busy. Busy then reads 1 for exactly 68 cycles when mode (control bits 1:0) is 0, and for exactly 36 cycles when mode is 1, 2 or 3. A write to the control address selects its mode from the written bits 1:0.
- R3: The quotient and remainder registers keep their previous contents while busy is set and change only at the edge that clears busy.
- R4: A qualifying write while busy is set abandons the running division. Busy then lasts a full period counted from that write, and the results come from the operand registers as they stand after it.
- R5: Mode 0 divides the low 32 bits of the numerator by the low 32 bits of the denominator, both signed. The upper operand halfwords are ignored, and both results are sign-extended to 64 bits.
- R6: Mode 1 divides the full 64-bit signed numerator by the sign-extended low 32 bits of the denominator.
- R7: Modes 2 and 3 divide the full 64-bit signed numerator by the full 64-bit signed denominator.
- R8: The quotient is truncated toward zero, and a nonzero remainder has the sign of the numerator.
- R9: With a zero effective denominator, control bit 14 is set at commit. The quotient is -1 for a non-negative numerator and +1 for a negative one, and the remainder equals the effective numerator. A later commit with a nonzero denominator clears bit 14.
- R10: The halfword address map is as follows. Address 0 holds the control word ({busy, zero-flag, 12 zero bits, mode}). Addresses 4-7 hold the numerator, 8-11 the denominator, 12-15 the quotient and 16-19 the remainder. In each group the least significant halfword sits at the lowest address. rd_data returns the addressed value one cycle after rd_addr is presented, and reading has no side effects.
- R11: Writes to the quotient or remainder addresses, or to unmapped addresses, change no register and do not set busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Halfword write strobe |
| wr_addr | input | ADDR_W | Halfword write address |
| wr_data | input | HW_W | Write data |
| rd_addr | input | ADDR_W | Halfword read address |
| rd_data | output | HW_W | Registered read data, one cycle after rd_addr |

## Verification
The assertions check several properties on every cycle. Every qualifying write raises busy on the next cycle, and busy never outlasts the mode's period counted from the latest write. The commit falls exactly on the last cycle of that period, with the divider already finished. The result registers stay stable on every other cycle, and the zero-divisor flag follows the denominator seen at commit. The arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover signed results in each mode, upper halfwords that are ignored, zero divisors of both numerator signs, and restarts that change the operands mid-flight. They also cover the address map, halfword order, and writes that must have no effect.

// File: rtl/divu_pkg.sv
package divu_pkg;

  typedef enum logic [1:0] {
    DM_32_32  = 2'd0,
    DM_64_32  = 2'd1,
    DM_64_64  = 2'd2,
    DM_64_64B = 2'd3
  } div_mode_e;

endpackage

// File: rtl/divu_core.sv
module divu_core #(
  parameter int W    = 64,
  parameter int STEP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         half_op,
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  output logic         done,
  output logic [W-1:0] q_mag,
  output logic [W-1:0] r_mag
);
  localparam int H     = W / 2;
  localparam int CNT_W = $clog2(W / STEP + 1);

  logic [W-1:0]     rem_q, sh_q, div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [W-1:0] rs [STEP+1];
  logic [W-1:0] ss [STEP+1];

  assign rs[0] = rem_q;
  assign ss[0] = sh_q;

  for (genvar i = 0; i < STEP; i++) begin : g_stage
    logic [W:0] trial;
    logic       ge;
    assign trial     = {rs[i], ss[i][W-1]};
    assign ge        = trial >= {1'b0, div_q};
    assign rs[i+1]   = ge ? (trial[W-1:0] - div_q) : trial[W-1:0];
    assign ss[i+1]   = {ss[i][W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      sh_q  <= '0;
      div_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      rem_q <= '0;
      sh_q  <= half_op ? {a_mag[H-1:0], {H{1'b0}}} : a_mag;
      div_q <= b_mag;
      cnt_q <= half_op ? CNT_W'(H / STEP) : CNT_W'(W / STEP);
      run_q <= 1'b1;
    end else if (run_q) begin
      rem_q <= rs[STEP];
      sh_q  <= ss[STEP];
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign done  = !run_q;
  assign q_mag = sh_q;
  assign r_mag = rem_q;
endmodule

// File: rtl/divu_sign.sv
module divu_sign
  import divu_pkg::*;
#(
  parameter int W = 64
) (
  input  div_mode_e    mode,
  input  logic [W-1:0] numer,
  input  logic [W-1:0] denom,
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         dz
);
  localparam int H = W / 2;

  logic [W-1:0] en, ed;
  logic         sn, sd;

  always_comb begin
    unique case (mode)
      DM_32_32: begin
        en = {{H{numer[H-1]}}, numer[H-1:0]};
        ed = {{H{denom[H-1]}}, denom[H-1:0]};
      end
      DM_64_32: begin
        en = numer;
        ed = {{H{denom[H-1]}}, denom[H-1:0]};
      end
      default: begin
        en = numer;
        ed = denom;
      end
    endcase
    sn    = en[W-1];
    sd    = ed[W-1];
    a_mag = sn ? -en : en;
    b_mag = sd ? -ed : ed;
    dz    = (ed == '0);
    if (dz) begin
      quot = sn ? W'(1) : '1;
      rem  = en;
    end else begin
      quot = (sn ^ sd) ? -q_mag : q_mag;
      rem  = sn ? -r_mag : r_mag;
    end
  end
endmodule

// File: rtl/divu_timer.sv
module divu_timer #(
  parameter int LAT_FULL = 68,
  parameter int LAT_FAST = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic fast,
  output logic busy,
  output logic fire
);
  localparam int CW = $clog2(LAT_FULL);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (restart) begin
      busy_q <= 1'b1;
      cnt_q  <= fast ? CW'(LAT_FAST - 1) : CW'(LAT_FULL - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign fire = busy_q && (cnt_q == '0) && !restart;
endmodule

// File: rtl/divu_top.sv
module divu_top
  import divu_pkg::*;
#(
  parameter int OP_W     = 64,
  parameter int HW_W     = 16,
  parameter int ADDR_W   = 5,
  parameter int LAT_FULL = 68,
  parameter int LAT_FAST = 36,
  parameter int STEP     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HW_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HW_W-1:0]   rd_data
);
  localparam int NHW   = OP_W / HW_W;
  localparam int IDX_W = $clog2(NHW);
  localparam int RG_W  = ADDR_W - IDX_W;
  localparam logic [RG_W-1:0] RG_CTRL = RG_W'(0);
  localparam logic [RG_W-1:0] RG_NUM  = RG_W'(1);
  localparam logic [RG_W-1:0] RG_DEN  = RG_W'(2);
  localparam logic [RG_W-1:0] RG_QUO  = RG_W'(3);
  localparam logic [RG_W-1:0] RG_REM  = RG_W'(4);

  logic [OP_W-1:0] numer_q, denom_q, quot_q, rem_q;
  div_mode_e       mode_q, mode_next;
  logic            dz_q, start_q;
  logic [HW_W-1:0] rd_data_q;

  logic [RG_W-1:0]  wr_rg, rd_rg;
  logic [IDX_W-1:0] wr_ix, rd_ix;
  logic             hit_ctrl, hit_num, hit_den, restart, fast_next;
  logic             busy, fire, core_done, dz_now;
  logic [OP_W-1:0]  a_mag, b_mag, q_mag, r_mag, quot_now, rem_now;
  logic [HW_W-1:0]  ctrl_word;

  assign wr_rg = wr_addr[ADDR_W-1:IDX_W];
  assign wr_ix = wr_addr[IDX_W-1:0];
  assign rd_rg = rd_addr[ADDR_W-1:IDX_W];
  assign rd_ix = rd_addr[IDX_W-1:0];

  assign hit_ctrl  = wr_en && (wr_rg == RG_CTRL) && (wr_ix == '0);
  assign hit_num   = wr_en && (wr_rg == RG_NUM);
  assign hit_den   = wr_en && (wr_rg == RG_DEN);
  assign restart   = hit_ctrl || hit_num || hit_den;
  assign mode_next = hit_ctrl ? div_mode_e'(wr_data[1:0]) : mode_q;
  assign fast_next = (mode_next != DM_32_32);

  divu_timer #(
    .LAT_FULL(LAT_FULL),
    .LAT_FAST(LAT_FAST)
  ) i_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .fast   (fast_next),
    .busy   (busy),
    .fire   (fire)
  );

  divu_sign #(
    .W(OP_W)
  ) i_sign (
    .mode (mode_q),
    .numer(numer_q),
    .denom(denom_q),
    .q_mag(q_mag),
    .r_mag(r_mag),
    .a_mag(a_mag),
    .b_mag(b_mag),
    .quot (quot_now),
    .rem  (rem_now),
    .dz   (dz_now)
  );

  divu_core #(
    .W   (OP_W),
    .STEP(STEP)
  ) i_core (
    .clk    (clk),
    .rst    (rst),
    .start  (start_q),
    .half_op(mode_q == DM_32_32),
    .a_mag  (a_mag),
    .b_mag  (b_mag),
    .done   (core_done),
    .q_mag  (q_mag),
    .r_mag  (r_mag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      numer_q <= '0;
      denom_q <= '0;
      quot_q  <= '0;
      rem_q   <= '0;
      mode_q  <= DM_32_32;
      dz_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= restart;
      if (hit_ctrl) mode_q <= mode_next;
      if (hit_num)  numer_q[wr_ix*HW_W +: HW_W] <= wr_data;
      if (hit_den)  denom_q[wr_ix*HW_W +: HW_W] <= wr_data;
      if (fire) begin
        quot_q <= quot_now;
        rem_q  <= rem_now;
        dz_q   <= dz_now;
      end
    end
  end

  assign ctrl_word = {busy, dz_q, {(HW_W-4){1'b0}}, 2'(mode_q)};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
    end else begin
      unique case (rd_rg)
        RG_CTRL: rd_data_q <= (rd_ix == '0) ? ctrl_word : '0;
        RG_NUM:  rd_data_q <= numer_q[rd_ix*HW_W +: HW_W];
        RG_DEN:  rd_data_q <= denom_q[rd_ix*HW_W +: HW_W];
        RG_QUO:  rd_data_q <= quot_q[rd_ix*HW_W +: HW_W];
        RG_REM:  rd_data_q <= rem_q[rd_ix*HW_W +: HW_W];
        default: rd_data_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/divu_chk.sv
module divu_chk #(
  parameter int OP_W     = 64,
  parameter int LAT_FULL = 68,
  parameter int LAT_FAST = 36
) (
  input logic            clk,
  input logic            rst,
  input logic            restart,
  input logic            fast,
  input logic            busy,
  input logic            fire,
  input logic            core_done,
  input logic            dz_now,
  input logic            dz_q,
  input logic [OP_W-1:0] quot_q,
  input logic [OP_W-1:0] rem_q
);
  localparam int CW = $clog2(LAT_FULL + 2);

  logic [CW-1:0] age_q, lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
      lat_q <= CW'(LAT_FULL);
    end else if (restart) begin
      age_q <= CW'(1);
      lat_q <= fast ? CW'(LAT_FAST) : CW'(LAT_FULL);
    end else if (busy) begin
      age_q <= age_q + 1'b1;
    end
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    restart |=> busy);                                           // R2

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (age_q <= lat_q));                                  // R2

  AST_COMMIT_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    fire |-> (age_q == lat_q));                                  // R4

  AST_BUSY_ENDS_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (fire && !restart) |=> !busy);                               // R2

  AST_CORE_READY: assert property (@(posedge clk) disable iff (rst)
    fire |-> core_done);                                         // R4

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(quot_q) && $stable(rem_q)));              // R3

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    fire |=> (dz_q == $past(dz_now)));                           // R9
endmodule

bind divu_top divu_chk #(
  .OP_W    (OP_W),
  .LAT_FULL(LAT_FULL),
  .LAT_FAST(LAT_FAST)
) i_divu_chk (
  .clk      (clk),
  .rst      (rst),
  .restart  (restart),
  .fast     (fast_next),
  .busy     (busy),
  .fire     (fire),
  .core_done(core_done),
  .dz_now   (dz_now),
  .dz_q     (dz_q),
  .quot_q   (quot_q),
  .rem_q    (rem_q)
);

// File: tb/test_divu_top.sv
module test_divu_top;
  localparam int AW = 5;
  localparam int HW = 16;
  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_NUM  = 5'd4;
  localparam logic [AW-1:0] A_DEN  = 5'd8;
  localparam logic [AW-1:0] A_QUO  = 5'd12;
  localparam logic [AW-1:0] A_REM  = 5'd16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [HW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [HW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  divu_top i_divu_top (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [HW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [HW-1:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd64(input logic [AW-1:0] base, output logic [63:0] v);
    for (int i = 0; i < 4; i++) begin
      logic [HW-1:0] h;
      rd(base + AW'(i), h);
      v[i*16 +: 16] = h;
    end
  endtask

  task automatic busy_len(output int n);
    logic [HW-1:0] v;
    n = 0;
    do begin
      rd(A_CTRL, v);
      if (v[15]) n++;
    end while (v[15] && n < 300);
  endtask

  task automatic load_ops(input logic [63:0] n, input logic [63:0] d);
    for (int i = 0; i < 4; i++) wr(A_NUM + AW'(i), n[i*16 +: 16]);
    for (int i = 0; i < 4; i++) wr(A_DEN + AW'(i), d[i*16 +: 16]);
  endtask

  function automatic void model(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                                output logic [63:0] q, output logic [63:0] r, output bit dz);
    longint a, b;
    if (m == 2'd0) begin
      a = {{32{n[31]}}, n[31:0]};
      b = {{32{d[31]}}, d[31:0]};
    end else if (m == 2'd1) begin
      a = n;
      b = {{32{d[31]}}, d[31:0]};
    end else begin
      a = n;
      b = d;
    end
    dz = (b == 0);
    if (dz) begin
      q = (a < 0) ? 64'd1 : '1;
      r = a;
    end else begin
      q = a / b;
      r = a % b;
    end
  endfunction

  task automatic run_div(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d, input string req);
    int len;
    logic [63:0] q, r, eq, er;
    logic [HW-1:0] c;
    bit dz;
    load_ops(n, d);
    wr(A_CTRL, {14'd0, m});
    busy_len(len);
    check(len == ((m == 2'd0) ? 68 : 36), {req, " R2 busy length"}, 64'(len), (m == 2'd0) ? 64'd68 : 64'd36);
    model(m, n, d, eq, er, dz);
    rd64(A_QUO, q);
    rd64(A_REM, r);
    check(q === eq, {req, " R8 quotient"}, q, eq);
    check(r === er, {req, " R8 remainder"}, r, er);
    rd(A_CTRL, c);
    check(c[14] == dz, {req, " R9 zero flag"}, 64'(c[14]), 64'(dz));
  endtask

  task automatic t_reset;
    logic [HW-1:0] v;
    logic [63:0] q;
    rd(A_CTRL, v);
    check(v === 16'h0, "R1 control after reset", 64'(v), 64'h0);
    rd64(A_QUO, q);
    check(q === 64'h0, "R1 quotient after reset", q, 64'h0);
  endtask

  task automatic t_modes;
    run_div(2'd0, 64'hDEAD_BEEF_FFFF_FFF9, 64'h1234_5678_0000_0002, "R5 mode0 -7/2");
    run_div(2'd0, 64'h0000_0000_0000_0064, 64'hFFFF_0000_FFFF_FFF9, "R5 mode0 100/-7");
    run_div(2'd1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_FFFD, "R6 mode1");
    run_div(2'd2, 64'hFFFF_FF17_2B5A_F3F9, 64'h0000_0000_0000_3039, "R7 mode2");
    run_div(2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFE_FFFF_FFFF, "R7 mode3");
  endtask

  task automatic t_zero;
    logic [HW-1:0] c;
    run_div(2'd2, 64'd5, 64'd0, "R9 zero pos");
    run_div(2'd0, 64'h0000_0000_FFFF_FFF7, 64'hABCD_0000_0000_0000, "R9 zero neg mode0");
    run_div(2'd2, 64'd9, 64'd3, "R9 clear");
    rd(A_CTRL, c);
    check(c[14] == 1'b0, "R9 flag cleared", 64'(c[14]), 64'd0);
  endtask

  task automatic t_restart;
    logic [63:0] prev, q, r;
    logic [HW-1:0] v;
    int len;
    rd64(A_QUO, prev);
    load_ops(64'd1000, 64'd7);
    wr(A_CTRL, 16'd2);
    for (int i = 0; i < 10; i++) begin
      rd(A_QUO, v);
      check(v === prev[15:0], "R3 quotient held while busy", 64'(v), 64'(prev[15:0]));
    end
    wr(A_DEN, 16'd9);
    busy_len(len);
    check(len == 36, "R4 busy restarted by operand write", 64'(len), 64'd36);
    rd64(A_QUO, q);
    rd64(A_REM, r);
    check(q === 64'd111, "R4 quotient from new denominator", q, 64'd111);
    check(r === 64'd1, "R4 remainder from new denominator", r, 64'd1);
  endtask

  task automatic t_ignore_and_map;
    logic [HW-1:0] v;
    logic [63:0] q;
    wr(A_QUO, 16'hBEEF);
    wr(A_REM + 5'd1, 16'h1234);
    wr(5'd25, 16'hFFFF);
    wr(5'd2, 16'h0003);
    rd(A_CTRL, v);
    check(v[15] == 1'b0, "R11 no busy after ignored writes", 64'(v), 64'(v & 16'h7FFF));
    check(v[1:0] == 2'd2, "R11 mode kept after unmapped write", 64'(v[1:0]), 64'd2);
    rd64(A_QUO, q);
    check(q === 64'd111, "R11 quotient unchanged", q, 64'd111);
    wr(A_NUM + 5'd3, 16'hA1B2);
    wr(A_NUM + 5'd0, 16'hC3D4);
    rd(A_CTRL, v);
    check(v[15] == 1'b1, "R2 numerator write sets busy", 64'(v[15]), 64'd1);
    rd64(A_NUM, q);
    check(q === 64'hA1B2_0000_0000_C3D4, "R10 numerator halfword order", q, 64'hA1B2_0000_0000_C3D4);
    rd64(A_NUM, q);
    check(q === 64'hA1B2_0000_0000_C3D4, "R10 reread without side effect", q, 64'hA1B2_0000_0000_C3D4);
    rd(A_CTRL, v);
    check(v[1:0] == 2'd2, "R10 control mode field", 64'(v[1:0]), 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_modes();
    t_zero();
    t_restart();
    t_ignore_and_map();
    repeat (80) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule